// File: doc/BRIEF.md
# Mixed-Width Dual-Port Bit Memory

A synchronous memory of 4096 bits with two fully independent ports. Each port has its own clock, enable, write enable, output clear, address, write data and registered read data. The data width of each port is chosen at elaboration from 1, 2, 4, 8 or 16 bits, and the two widths need not match. Both ports see the same linear bit array. A port of width W at word address N covers bits N*W through N*W+W-1, so a word written through the narrow port can be read back through the wide one, and the reverse.

Contents come from a 4096-bit initial image supplied as a parameter. Bit k of the image is stored in memory bit k, and the image is made of sixteen 256-bit words: word j fills bits 256*j up to 256*j+255. Any part left at its default is zero. An asynchronous global reset clears both read-data registers and leaves the stored bits alone.

Two accesses that touch the same bits on the same cycle, with at least one of them a write, are not resolved. The block raises a per-port hazard flag for those cycles, and the read or stored data they produce is undefined.

Top module: `mwDualRam`

## Requirements
- R1: Widths are limited to 1, 2, 4, 8 and 16; any other value stops elaboration. A port of width W has an address of log2(4096/W) bits (12, 11, 10, 9, 8), and its top address reaches the top W bits of the array.
- R2: A port of width W at address N reads and writes bits N*W up to N*W+W-1 of the shared array, with the lowest bit of the port data on bit N*W. Data written through one port is visible through the other port at the matching bit range.
- R3: With enable low, a port writes nothing and its read data keeps its value, whatever write enable, clear, address and data are.
- R4: With enable and clear high at a rising edge, the read data becomes zero; if write enable is also high, the write still happens.
- R5: With enable high and write enable and clear low, the addressed word appears on the read data after that rising edge.
- R6: With enable and write enable high and clear low, the write data is stored and is also the read data after that edge (write-first).
- R7: Global reset forces both read-data outputs to zero at once and keeps the stored bits.
- R8: Memory bit k starts as bit k of the initial image; parts of the image not given are zero.
- R9: Both hazard flags are high, in the same cycle as the inputs, exactly when both ports are enabled, their bit ranges overlap, and at least one of them has write enable high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| glbRst | input | 1 | Asynchronous global reset of both read-data registers, active high |
| clkA | input | 1 | Clock of port A |
| enA | input | 1 | Port A enable |
| weA | input | 1 | Port A write enable |
| rstA | input | 1 | Port A synchronous read-data clear |
| addrA | input | log2(4096/WIDTH_A) | Port A word address |
| dinA | input | WIDTH_A | Port A write data |
| doutA | output | WIDTH_A | Port A registered read data |
| collA | output | 1 | Hazard flag seen from port A |
| clkB | input | 1 | Clock of port B |
| enB | input | 1 | Port B enable |
| weB | input | 1 | Port B write enable |
| rstB | input | 1 | Port B synchronous read-data clear |
| addrB | input | log2(4096/WIDTH_B) | Port B word address |
| dinB | input | WIDTH_B | Port B write data |
| doutB | output | WIDTH_B | Port B registered read data |
| collB | output | 1 | Hazard flag seen from port B |

## Verification
The bench runs the 4-bit and 16-bit port pair against a bit-level model with a non-zero initial image, so reads of the first and last image words tell apart a correct bit numbering from a shifted or reversed one. Narrow writes read back through the wide port, and wide writes read back through the narrow port, separate the slice placement of each width. Writes on both ports in the same cycle to separate rows show that neither write disturbs the other. Enable-low writes, clear with and without write, and a global reset followed by reads show which of output and memory each control touches. Overlapping and adjacent address pairs, with and without a write, mark the edges of the hazard flag.

// File: rtl/mwRamPkg.sv
`timescale 1ns/1ps
package mwRamPkg;

  // Storage geometry: the array is held as rows of the widest port width.
  localparam int TOTAL_BITS   = 4096;
  localparam int ROW_BITS     = 16;
  localparam int ROWS         = TOTAL_BITS / ROW_BITS;
  localparam int BIT_IDX_BITS = $clog2(TOTAL_BITS);
  localparam int COL_SEL_BITS = $clog2(ROW_BITS);
  localparam int ROW_SEL_BITS = BIT_IDX_BITS - COL_SEL_BITS;

  // Strobes from a port's control decode to the datapath.
  typedef struct packed {
    logic clrOut;   // clear read-data register
    logic loadMem;  // load read-data register from memory
    logic loadDin;  // load read-data register from write data
    logic wrMem;    // store write data
  } portStb_t;

  function automatic bit widthOk(input int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == ROW_BITS);
  endfunction

  function automatic int addrBits(input int w);
    return $clog2(TOTAL_BITS / w);
  endfunction

endpackage

// File: rtl/mwPortCtrl.sv
`timescale 1ns/1ps
module mwPortCtrl
  import mwRamPkg::*;
(
  input  logic     en,
  input  logic     we,
  input  logic     rst,
  output portStb_t stb
);

  // Clear wins over both read and write-through for the output register,
  // but never blocks the memory write.
  always_comb begin
    stb         = '0;
    stb.wrMem   = en & we;
    stb.clrOut  = en & rst;
    stb.loadDin = en & ~rst & we;
    stb.loadMem = en & ~rst & ~we;
  end

endmodule

// File: rtl/mwCollide.sv
`timescale 1ns/1ps
module mwCollide
  import mwRamPkg::*;
#(
  parameter int WIDTH_A = 4,
  parameter int WIDTH_B = 16,
  localparam int AW_A   = addrBits(WIDTH_A),
  localparam int AW_B   = addrBits(WIDTH_B)
) (
  input  logic            enA,
  input  logic            weA,
  input  logic [AW_A-1:0] addrA,
  input  logic            enB,
  input  logic            weB,
  input  logic [AW_B-1:0] addrB,
  output logic            hit
);

  localparam int LOG_A  = $clog2(WIDTH_A);
  localparam int LOG_B  = $clog2(WIDTH_B);
  localparam int SPAN   = (LOG_A > LOG_B) ? LOG_A : LOG_B;

  logic [BIT_IDX_BITS-1:0] startA;
  logic [BIT_IDX_BITS-1:0] startB;
  logic                    overlap;

  // Power-of-two ranges aligned to their own size overlap exactly when
  // both fall in the same block of the larger width.
  always_comb begin
    startA  = BIT_IDX_BITS'(addrA) << LOG_A;
    startB  = BIT_IDX_BITS'(addrB) << LOG_B;
    overlap = (startA >> SPAN) == (startB >> SPAN);
    hit     = enA & enB & (weA | weB) & overlap;
  end

endmodule

// File: rtl/mwRamCore.sv
`timescale 1ns/1ps
module mwRamCore
  import mwRamPkg::*;
#(
  parameter int WIDTH_A = 4,
  parameter int WIDTH_B = 16,
  parameter logic [TOTAL_BITS-1:0] INIT_IMAGE = '0,
  localparam int AW_A = addrBits(WIDTH_A),
  localparam int AW_B = addrBits(WIDTH_B)
) (
  input  logic               glbRst,
  input  logic               clkA,
  input  portStb_t           stbA,
  input  logic [AW_A-1:0]    addrA,
  input  logic [WIDTH_A-1:0] dinA,
  output logic [WIDTH_A-1:0] doutA,
  input  logic               clkB,
  input  portStb_t           stbB,
  input  logic [AW_B-1:0]    addrB,
  input  logic [WIDTH_B-1:0] dinB,
  output logic [WIDTH_B-1:0] doutB
);

  localparam int LOG_A = $clog2(WIDTH_A);
  localparam int LOG_B = $clog2(WIDTH_B);

  // Two banks, each written by one port only; stored value is their XOR.
  logic [ROW_BITS-1:0] bankA [ROWS];
  logic [ROW_BITS-1:0] bankB [ROWS];

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      bankA[r] = INIT_IMAGE[r*ROW_BITS +: ROW_BITS];
      bankB[r] = '0;
    end
  end

  // ---------------- port A addressing ----------------
  logic [BIT_IDX_BITS-1:0] startA;
  logic [ROW_SEL_BITS-1:0] rowA;
  logic [COL_SEL_BITS-1:0] colA;
  logic [ROW_BITS-1:0]     rowValA;
  logic [WIDTH_A-1:0]      rdA;
  logic [WIDTH_A-1:0]      otherA;

  always_comb begin
    startA  = BIT_IDX_BITS'(addrA) << LOG_A;
    rowA    = startA[BIT_IDX_BITS-1:COL_SEL_BITS];
    colA    = startA[COL_SEL_BITS-1:0];
    rowValA = bankA[rowA] ^ bankB[rowA];
    rdA     = rowValA[colA +: WIDTH_A];
    otherA  = bankB[rowA][colA +: WIDTH_A];
  end

  always_ff @(posedge clkA) begin
    if (stbA.wrMem) begin
      bankA[rowA][colA +: WIDTH_A] <= dinA ^ otherA;
    end
  end

  always_ff @(posedge clkA or posedge glbRst) begin
    if (glbRst) begin
      doutA <= '0;
    end else if (stbA.clrOut) begin
      doutA <= '0;
    end else if (stbA.loadDin) begin
      doutA <= dinA;
    end else if (stbA.loadMem) begin
      doutA <= rdA;
    end
  end

  // ---------------- port B addressing ----------------
  logic [BIT_IDX_BITS-1:0] startB;
  logic [ROW_SEL_BITS-1:0] rowB;
  logic [COL_SEL_BITS-1:0] colB;
  logic [ROW_BITS-1:0]     rowValB;
  logic [WIDTH_B-1:0]      rdB;
  logic [WIDTH_B-1:0]      otherB;

  always_comb begin
    startB  = BIT_IDX_BITS'(addrB) << LOG_B;
    rowB    = startB[BIT_IDX_BITS-1:COL_SEL_BITS];
    colB    = startB[COL_SEL_BITS-1:0];
    rowValB = bankA[rowB] ^ bankB[rowB];
    rdB     = rowValB[colB +: WIDTH_B];
    otherB  = bankA[rowB][colB +: WIDTH_B];
  end

  always_ff @(posedge clkB) begin
    if (stbB.wrMem) begin
      bankB[rowB][colB +: WIDTH_B] <= dinB ^ otherB;
    end
  end

  always_ff @(posedge clkB or posedge glbRst) begin
    if (glbRst) begin
      doutB <= '0;
    end else if (stbB.clrOut) begin
      doutB <= '0;
    end else if (stbB.loadDin) begin
      doutB <= dinB;
    end else if (stbB.loadMem) begin
      doutB <= rdB;
    end
  end

  // ---------------- assertions ----------------
  AST_A_HOLD_IDLE: assert property (@(posedge clkA) disable iff (glbRst)
    !(stbA.clrOut | stbA.loadMem | stbA.loadDin) |=> $stable(doutA)); // R3
  AST_B_HOLD_IDLE: assert property (@(posedge clkB) disable iff (glbRst)
    !(stbB.clrOut | stbB.loadMem | stbB.loadDin) |=> $stable(doutB)); // R3
  AST_A_CLEAR: assert property (@(posedge clkA) disable iff (glbRst)
    stbA.clrOut |=> (doutA == '0)); // R4
  AST_B_CLEAR: assert property (@(posedge clkB) disable iff (glbRst)
    stbB.clrOut |=> (doutB == '0)); // R4
  AST_A_WRITE_THROUGH: assert property (@(posedge clkA) disable iff (glbRst)
    stbA.loadDin |=> (doutA == $past(dinA))); // R6
  AST_B_WRITE_THROUGH: assert property (@(posedge clkB) disable iff (glbRst)
    stbB.loadDin |=> (doutB == $past(dinB))); // R6
  AST_A_STROBE_EXCL: assert property (@(posedge clkA) disable iff (glbRst)
    $onehot0({stbA.clrOut, stbA.loadMem, stbA.loadDin})); // R4
  AST_B_STROBE_EXCL: assert property (@(posedge clkB) disable iff (glbRst)
    $onehot0({stbB.clrOut, stbB.loadMem, stbB.loadDin})); // R4

endmodule

// File: rtl/mwDualRam.sv
`timescale 1ns/1ps
module mwDualRam
  import mwRamPkg::*;
#(
  parameter int WIDTH_A = 4,
  parameter int WIDTH_B = 16,
  parameter logic [TOTAL_BITS-1:0] INIT_IMAGE = '0,
  localparam int AW_A = addrBits(WIDTH_A),
  localparam int AW_B = addrBits(WIDTH_B)
) (
  input  logic               glbRst,
  input  logic               clkA,
  input  logic               enA,
  input  logic               weA,
  input  logic               rstA,
  input  logic [AW_A-1:0]    addrA,
  input  logic [WIDTH_A-1:0] dinA,
  output logic [WIDTH_A-1:0] doutA,
  output logic               collA,
  input  logic               clkB,
  input  logic               enB,
  input  logic               weB,
  input  logic               rstB,
  input  logic [AW_B-1:0]    addrB,
  input  logic [WIDTH_B-1:0] dinB,
  output logic [WIDTH_B-1:0] doutB,
  output logic               collB
);

  // R1: reject unsupported widths while elaborating.
  if (!widthOk(WIDTH_A)) begin : g_badWidthA
    initial $fatal(1, "mwDualRam: WIDTH_A=%0d not in {1,2,4,8,16}", WIDTH_A);
  end
  if (!widthOk(WIDTH_B)) begin : g_badWidthB
    initial $fatal(1, "mwDualRam: WIDTH_B=%0d not in {1,2,4,8,16}", WIDTH_B);
  end

  portStb_t stbA;
  portStb_t stbB;
  logic     hazard;

  mwPortCtrl u_ctrlA (.en(enA), .we(weA), .rst(rstA), .stb(stbA));
  mwPortCtrl u_ctrlB (.en(enB), .we(weB), .rst(rstB), .stb(stbB));

  mwRamCore #(
    .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B), .INIT_IMAGE(INIT_IMAGE)
  ) u_core (
    .glbRst(glbRst),
    .clkA(clkA), .stbA(stbA), .addrA(addrA), .dinA(dinA), .doutA(doutA),
    .clkB(clkB), .stbB(stbB), .addrB(addrB), .dinB(dinB), .doutB(doutB)
  );

  mwCollide #(.WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B)) u_coll (
    .enA(enA), .weA(weA), .addrA(addrA),
    .enB(enB), .weB(weB), .addrB(addrB),
    .hit(hazard)
  );

  assign collA = hazard;
  assign collB = hazard;

  AST_HAZARD_NEEDS_WRITE: assert property (@(posedge clkA) disable iff (glbRst)
    collA |-> (enA && enB && (weA || weB))); // R9

endmodule

// File: tb/mwDualRam_tb_top.sv
`timescale 1ns/1ps
module mwDualRam_tb_top;

  localparam int WA = 4;
  localparam int WB = 16;
  localparam logic [4095:0] TB_INIT =
    {{16{16'hC3A5}}, {(14*256){1'b0}}, {16{16'h1234}}};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic glbRst = 1'b1;
  logic enA = 0, weA = 0, rstA = 0;
  logic [9:0] addrA = '0;
  logic [3:0] dinA = '0;
  logic [3:0] doutA;
  logic collA;
  logic enB = 0, weB = 0, rstB = 0;
  logic [7:0] addrB = '0;
  logic [15:0] dinB = '0;
  logic [15:0] doutB;
  logic collB;

  mwDualRam #(.WIDTH_A(WA), .WIDTH_B(WB), .INIT_IMAGE(TB_INIT)) dut_i (
    .glbRst(glbRst),
    .clkA(clk), .enA(enA), .weA(weA), .rstA(rstA), .addrA(addrA),
    .dinA(dinA), .doutA(doutA), .collA(collA),
    .clkB(clk), .enB(enB), .weB(weB), .rstB(rstB), .addrB(addrB),
    .dinB(dinB), .doutB(doutB), .collB(collB)
  );

  typedef struct {
    bit en; bit we; bit rst; int addr; logic [15:0] din; bit chk; string req;
  } op_t;
  typedef struct { bit isB; logic [15:0] val; string req; } exp_t;

  exp_t sbQ[$];
  logic [4095:0] model = TB_INIT;
  logic [15:0] expA = '0;
  logic [15:0] expB = '0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic op_t mk(bit en, bit we, bit rst, int addr,
                             logic [15:0] din, bit chk, string req);
    op_t o;
    o.en = en; o.we = we; o.rst = rst; o.addr = addr;
    o.din = din; o.chk = chk; o.req = req;
    return o;
  endfunction

  function automatic op_t idle();
    return mk(0, 0, 0, 0, 16'h0, 0, "");
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: applies one cycle on both ports, advances the bit model and
  // queues the outputs expected after the coming rising edge.
  // expColl: -1 no check, else expected value of both hazard flags.
  task automatic cyc(op_t a, op_t b, int expColl = -1);
    logic [15:0] nA, nB;
    exp_t e;
    @(negedge clk); #0.5;
    enA = a.en; weA = a.we; rstA = a.rst; addrA = a.addr[9:0]; dinA = a.din[3:0];
    enB = b.en; weB = b.we; rstB = b.rst; addrB = b.addr[7:0]; dinB = b.din;
    nA = expA; nB = expB;
    if (a.en) nA = a.rst ? 16'h0 : (a.we ? {12'h0, a.din[3:0]}
                                          : {12'h0, model[a.addr*WA +: WA]});
    if (b.en) nB = b.rst ? 16'h0 : (b.we ? b.din : model[b.addr*WB +: WB]);
    if (a.en && a.we) model[a.addr*WA +: WA] = a.din[3:0];
    if (b.en && b.we) model[b.addr*WB +: WB] = b.din;
    expA = nA; expB = nB;
    if (a.chk) begin e.isB = 0; e.val = nA; e.req = a.req; sbQ.push_back(e); end
    if (b.chk) begin e.isB = 1; e.val = nB; e.req = b.req; sbQ.push_back(e); end
    if (expColl >= 0) begin
      #0.5;
      check(collA === expColl[0], "R9 collA", {15'h0, collA}, {15'h0, expColl[0]});
      check(collB === expColl[0], "R9 collB", {15'h0, collB}, {15'h0, expColl[0]});
    end
    @(posedge clk);
  endtask

  // Monitor: compares queued expectations just after each rising edge.
  initial begin
    forever begin
      @(posedge clk); #1;
      while (sbQ.size() > 0) begin
        exp_t e;
        logic [15:0] act;
        e = sbQ.pop_front();
        act = e.isB ? doutB : {12'h0, doutA};
        check(act === e.val, e.req, act, e.val);
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R7: outputs zero while global reset is held
    repeat (3) @(posedge clk);
    #1;
    check(doutA === 4'h0, "R7 reset doutA", {12'h0, doutA}, 16'h0);
    check(doutB === 16'h0, "R7 reset doutB", doutB, 16'h0);
    @(negedge clk); glbRst = 0;

    // R8 / R1 / R5: initial image and address extremes
    cyc(mk(1,0,0,0,0,1,"R8 A init word0"), mk(1,0,0,0,0,1,"R8 B init word0"));
    cyc(mk(1,0,0,1023,0,1,"R1 A top addr"), mk(1,0,0,255,0,1,"R1 B top addr"));
    cyc(mk(1,0,0,1,0,1,"R5 A read"), mk(1,0,0,16,0,1,"R8 B unspecified zero"));

    // R6 narrow writes show write-through, B idle holds (R3)
    for (int i = 0; i < 4; i++)
      cyc(mk(1,1,0,40+i,16'(i+1),1,"R6 A write-first"), mk(0,1,0,3,16'hFFFF,1,"R3 B hold"));
    cyc(idle(), mk(1,0,0,10,0,1,"R2 B sees A nibbles"));

    // R2 wide write read back through narrow port
    cyc(idle(), mk(1,1,0,20,16'hBEEF,1,"R6 B write-first"));
    for (int i = 0; i < 4; i++)
      cyc(mk(1,0,0,80+i,0,1,"R2 A sees B nibble"), idle());

    // Both ports write different rows in one cycle
    cyc(mk(1,1,0,200,16'h9,1,"R6 A dual write"), mk(1,1,0,60,16'h5A5A,1,"R6 B dual write"), 0);
    cyc(mk(1,0,0,240,0,1,"R2 A reads B row"), mk(1,0,0,50,0,1,"R2 B reads A row"));

    // R3: disabled write has no effect
    cyc(mk(0,1,0,80,16'h0,1,"R3 A hold"), idle());
    cyc(mk(1,0,0,80,0,1,"R3 A no write"), idle());

    // R4: clear with and without write
    cyc(mk(1,1,1,81,16'h7,1,"R4 A clear+write"), mk(1,0,1,20,0,1,"R4 B clear"));
    cyc(mk(0,0,1,81,0,1,"R3 A clear ignored when disabled"), idle());
    cyc(mk(1,0,0,81,0,1,"R4 A write under clear"), mk(1,0,0,20,0,1,"R4 B sees write"));

    // R7: global reset mid-run keeps memory
    @(negedge clk); glbRst = 1; #1;
    check(doutA === 4'h0, "R7 async doutA", {12'h0, doutA}, 16'h0);
    check(doutB === 16'h0, "R7 async doutB", doutB, 16'h0);
    @(negedge clk); glbRst = 0; expA = '0; expB = '0;
    cyc(mk(1,0,0,0,0,1,"R7 A memory kept"), mk(1,0,0,20,0,1,"R7 B memory kept"));

    // R9: hazard flag cases
    cyc(mk(1,1,0,0,16'h5,1,"R6 A write in hazard"), mk(1,0,0,0,0,0,""), 1);
    cyc(mk(1,1,0,0,16'h4,1,"R6 A restore"), mk(1,0,1,0,0,1,"R4 B clear"), 1);
    cyc(mk(1,1,0,0,16'h4,1,"R6 A write"), mk(1,0,0,1,0,1,"R9 B adjacent read"), 0);
    cyc(mk(1,0,0,0,0,1,"R9 A shared read"), mk(1,0,0,0,0,1,"R9 B shared read"), 0);
    cyc(mk(1,1,0,4,16'h1,1,"R6 A write"), mk(0,0,0,1,0,1,"R3 B hold"), 0);
    cyc(mk(1,0,0,5,0,0,""), mk(1,1,0,1,16'h1234,1,"R6 B write in hazard"), 1);
    cyc(mk(1,0,0,4,0,1,"R9 A after hazard"), idle(), 0);

    repeat (3) @(posedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule